// File: doc/BRIEF.md
# GPIO Port Register Block

This block is one 8-bit general-purpose I/O port that sits behind a small microcontroller register bus. Software reaches it through three word addresses. The first holds the output value of each pin. The second holds the direction of each pin. The third returns the synchronised pad levels on reads. A word write to the third address flips every output bit whose write-data bit is one.

The block also accepts single-bit operations. Each one carries a register select, a bit index and a value, and changes exactly one bit in one cycle, so firmware never needs a read-modify-write sequence on the port.

Toward the pads the block drives a per-pin output enable, an output value and a pull-up enable. The pull-up of a pin is on only when the pin is an input, its output bit is one, and the global pull-up disable input from system control is low. Pad levels pass through a two-stage synchroniser before any read can see them.

Top module: `gpio_port`

## Requirements
- R1: Synchronous reset clears the output and direction registers, pad_oe, pad_out, pad_pu and bus_rdata to zero.
- R2: A word write (bus_we=1) to select 0 loads the output register, and a write to select 1 loads the direction register. pad_out and pad_oe show the new value after the write's clock edge.
- R3: A word write to select 2 inverts each output-register bit whose bus_wdata bit is 1 and leaves bits written 0 unchanged.
- R4: A bit operation (bit_en=1, bus_we=0) with bit_sel 0 or 1 sets bit bit_idx of the output or direction register to bit_val. All other bits of both registers are unchanged.
- R5: A bit operation with bit_sel 2 and bit_val=1 inverts output bit bit_idx. With bit_val=0 it changes nothing.
- R6: When a word write and a bit operation arrive in the same cycle, only the word write takes effect.
- R7: pad_pu[n] is registered and equals NOT pud AND NOT dir[n] AND out[n]. It lags the registers by one clock, so it updates two edges after a write is presented.
- R8: While pud is 1, pad_pu is all zero from the next edge on, whatever the registers hold.
- R9: A read at select 2 returns pad_in passed through two synchroniser flops plus the read register. A change on pad_in appears on bus_rdata on the third edge after it.
- R10: bus_rdata is registered and shows, one edge after bus_sel is presented, the output register (0), the direction register (1) or the synchronised pins (2). Select 3 reads as zero, and writes to select 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Word register select: 0 output, 1 direction, 2 pins, 3 unused |
| bus_we | input | 1 | Word write strobe |
| bus_wdata | input | W | Word write data |
| bus_rdata | output | W | Registered read data for bus_sel |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_sel | input | 2 | Register select for the bit operation, same coding as bus_sel |
| bit_idx | input | IDX_W | Bit number addressed by the bit operation |
| bit_val | input | 1 | Value written (or toggle request when bit_sel is 2) |
| pud | input | 1 | Global pull-up disable |
| pad_in | input | W | Asynchronous pad input levels |
| pad_oe | output | W | Per-pin output enable (1 = drive) |
| pad_out | output | W | Per-pin output value |
| pad_pu | output | W | Per-pin pull-up enable |

## Verification
Each result in this block has its own latency. pad_out and pad_oe change one edge after a write is presented, and pad_pu changes two edges after. A change of pud moves pad_pu one edge later. A register read is due one edge after bus_sel is set, and a pin change reaches bus_rdata on the third edge. Every driver task stamps each expected item with the cycle at which its result is due. The monitor compares only in that cycle, and it does so on the falling edge. Two kinds of wait keep the checks apart: a write is followed by an idle cycle, and pud changes wait for pending pull-up checks to retire, so no item depends on two stimuli at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } port_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      p_sync_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(async_in, 2)))
        else $error("synchroniser latency broken");
    end
  endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter  int W     = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  port_sel_e        sel,
  input  logic [W-1:0]     wdata,
  input  logic             bop_en,
  input  port_sel_e        bop_sel,
  input  logic [IDX_W-1:0] bop_idx,
  input  logic             bop_val,
  output logic [W-1:0]     data_q,
  output logic [W-1:0]     dir_q
);

  logic [W-1:0] data_n, dir_n;

  always_comb begin
    data_n = data_q;
    dir_n  = dir_q;
    if (we) begin
      unique case (sel)
        SEL_OUT: data_n = wdata;
        SEL_DIR: dir_n  = wdata;
        SEL_PIN: data_n = data_q ^ wdata;
        default: ;
      endcase
    end else if (bop_en && (int'(bop_idx) < W)) begin
      unique case (bop_sel)
        SEL_OUT: data_n[bop_idx] = bop_val;
        SEL_DIR: dir_n[bop_idx]  = bop_val;
        SEL_PIN: if (bop_val) data_n[bop_idx] = ~data_q[bop_idx];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_n;
      dir_q  <= dir_n;
    end
  end

  p_pin_zero_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_PIN && wdata == '0) |=> (data_q == $past(data_q)))
    else $error("zero toggle mask altered data");

  p_bitop_single_r4: assert property (@(posedge clk) disable iff (rst)
    (bop_en && !we) |=>
      ($countones({data_q ^ $past(data_q), dir_q ^ $past(dir_q)}) <= 1))
    else $error("bit operation touched more than one bit");

  p_word_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_DIR && bop_en) |=> (dir_q == $past(wdata)))
    else $error("word write lost against bit operation");

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pud,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);

  assign pad_oe  = dir_q;
  assign pad_out = data_q;

  generate
    for (genvar n = 0; n < W; n++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) pad_pu[n] <= 1'b0;
        else     pad_pu[n] <= ~pud & ~dir_q[n] & data_q[n];
      end
    end
  endgenerate

  p_pud_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    pud |=> (pad_pu == '0))
    else $error("pull-up active while disabled");

  p_pu_inputs_only_r7: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu & $past(dir_q)) == '0))
    else $error("pull-up on an output pin");

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter  int W     = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_sel,
  input  logic             bus_we,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic             bit_en,
  input  logic [1:0]       bit_sel,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  input  logic             pud,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_pu
);

  localparam int SYNC_STAGES = 2;

  port_sel_e    sel, bsel;
  logic [W-1:0] data_q, dir_q, pins_s;

  assign sel  = port_sel_e'(bus_sel);
  assign bsel = port_sel_e'(bit_sel);

  gpio_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .sel     (sel),
    .wdata   (bus_wdata),
    .bop_en  (bit_en),
    .bop_sel (bsel),
    .bop_idx (bit_idx),
    .bop_val (bit_val),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  gpio_pad_ctrl #(.W(W)) u_pad (
    .clk     (clk),
    .rst     (rst),
    .pud     (pud),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_OUT: bus_rdata <= data_q;
        SEL_DIR: bus_rdata <= dir_q;
        SEL_PIN: bus_rdata <= pins_s;
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_reserved_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (bus_rdata == '0))
    else $error("unused select returned data");

  p_unused_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == SEL_NONE) |=> (pad_out == $past(pad_out) && pad_oe == $past(pad_oe)))
    else $error("write to unused select changed state");

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

  localparam int W = 8;

  typedef struct {
    int          due;
    int          kind;   // 0 pad_out, 1 pad_oe, 2 pad_pu, 3 bus_rdata
    logic [W-1:0] exp;
    string       req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_sel = 2'd0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         bit_en = 1'b0;
  logic [1:0]   bit_sel = 2'd0;
  logic [2:0]   bit_idx = 3'd0;
  logic         bit_val = 1'b0;
  logic         pud = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  item_t q[$];

  logic [W-1:0] m_data = '0, m_dir = '0, m_pins = '0;
  logic         m_pud = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_port #(.W(W)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_en(bit_en),
    .bit_sel(bit_sel), .bit_idx(bit_idx), .bit_val(bit_val), .pud(pud),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  function automatic logic [W-1:0] exp_pu();
    return (m_pud ? '0 : (~m_dir & m_data));
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return m_data;
      2'd1:    return m_dir;
      2'd2:    return m_pins;
      default: return '0;
    endcase
  endfunction

  task automatic push(input int due, input int kind, input logic [W-1:0] e, input string r);
    item_t it;
    it.due = due; it.kind = kind; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic push_regs(input string r);
    push(cyc + 1, 0, m_data, r);
    push(cyc + 1, 1, m_dir, r);
    push(cyc + 2, 2, exp_pu(), "R7");
  endtask

  task automatic apply_word(input logic [1:0] s, input logic [W-1:0] v);
    case (s)
      2'd0: m_data = v;
      2'd1: m_dir  = v;
      2'd2: m_data = m_data ^ v;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] v, input string r);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b1; bus_wdata = v;
    apply_word(s, v);
    push_regs(r);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bop(input logic [1:0] s, input int idx, input logic v, input string r);
    @(negedge clk);
    bit_en = 1'b1; bit_sel = s; bit_idx = 3'(idx); bit_val = v;
    case (s)
      2'd0: m_data[idx] = v;
      2'd1: m_dir[idx]  = v;
      2'd2: if (v) m_data[idx] = ~m_data[idx];
      default: ;
    endcase
    push_regs(r);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic wr_and_bop(input logic [1:0] s, input logic [W-1:0] v,
                            input logic [1:0] bs, input int idx, input logic bv);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b1; bus_wdata = v;
    bit_en = 1'b1; bit_sel = bs; bit_idx = 3'(idx); bit_val = bv;
    apply_word(s, v);            // R6: bit operation dropped
    push_regs("R6");
    @(negedge clk);
    bus_we = 1'b0; bit_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input string r);
    @(negedge clk);
    bus_sel = s;
    push(cyc + 1, 3, exp_rd(s), r);
    @(negedge clk);
  endtask

  task automatic set_pud(input logic v);
    @(negedge clk);
    @(negedge clk);
    pud = v; m_pud = v;
    push(cyc + 1, 2, exp_pu(), "R8");
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [W-1:0] got;
      it = q.pop_front();
      case (it.kind)
        0: got = pad_out;
        1: got = pad_oe;
        2: got = pad_pu;
        default: got = bus_rdata;
      endcase
      checks++;
      if (it.due != cyc) begin
        errors++;
        $display("FAIL %s kind %0d missed due cycle %0d (now %0d) actual %h expected %h",
                 it.req, it.kind, it.due, cyc, got, it.exp);
      end else if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d cycle %0d actual %h expected %h",
                 it.req, it.kind, cyc, got, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    push(cyc + 1, 0, '0, "R1");
    push(cyc + 1, 1, '0, "R1");
    push(cyc + 1, 2, '0, "R1");
    push(cyc + 1, 3, '0, "R1");
    @(negedge clk);
    rst = 1'b0;

    // R2: word writes
    wr(2'd0, 8'hA5, "R2");
    wr(2'd1, 8'h0F, "R2");
    // R10: register reads
    rd(2'd0, "R10");
    rd(2'd1, "R10");
    // R3: toggle through pins address
    wr(2'd2, 8'h3C, "R3");       // A5 -> 99
    wr(2'd2, 8'h00, "R3");       // unchanged
    rd(2'd0, "R3");
    // R4: single-bit set/clear
    bop(2'd0, 2, 1'b1, "R4");    // 9D
    bop(2'd0, 0, 1'b0, "R4");    // 9C
    bop(2'd1, 7, 1'b1, "R4");    // dir 8F
    bop(2'd1, 0, 1'b0, "R4");    // dir 8E
    // R5: bit toggle
    bop(2'd2, 6, 1'b1, "R5");    // DC
    bop(2'd2, 6, 1'b0, "R5");    // unchanged
    // R6: word write beats bit operation
    wr_and_bop(2'd1, 8'h00, 2'd1, 1, 1'b1);
    rd(2'd1, "R6");
    // R8 / R7: pull-up control
    set_pud(1'b1);
    wr(2'd0, 8'hFF, "R8");
    set_pud(1'b0);
    wr(2'd1, 8'hF0, "R7");
    // R9: synchronised pins
    @(negedge clk);
    bus_sel = 2'd2; pad_in = 8'h5A; m_pins = 8'h5A;
    repeat (4) @(negedge clk);
    rd(2'd2, "R9");
    @(negedge clk);
    pad_in = 8'hC3;
    push(cyc + 1, 3, 8'h5A, "R9");
    push(cyc + 2, 3, 8'h5A, "R9");
    push(cyc + 3, 3, 8'hC3, "R9");
    m_pins = 8'hC3;
    repeat (4) @(negedge clk);
    // R10: unused select
    rd(2'd3, "R10");
    wr(2'd3, 8'h55, "R10");
    rd(2'd0, "R10");

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule